// File: doc/BRIEF.md
# Self-Select Priority Bus Hub

This block connects one bus host to a parameterised number of device ports. The hub holds no address map. Each device decodes the host address itself and raises its own active flag when the address falls inside its window. The hub sends the host's address, write word and byte-lane write mask unchanged to every device port. It passes a priority encoder over the active flags to choose a single device.

Only the chosen device receives the host's read and write enables. The host's read word and ready flag are taken from that device alone. If no device claims the access, the host sees a zero read word and a low ready, and no device sees an enable. Device 0 has the highest priority. A higher port index means a lower priority.

The whole path is combinational and holds no state, so a selection adds no cycle of latency. A parameter picks the encoder structure. One variant isolates the lowest set bit arithmetically; the other is a blocking chain.

Top module: `bus_hub_selfsel`

## Requirements
- R1: Every device port carries the host address, write word and byte mask unchanged, whether or not that device is selected. Mask bit k covers write-word bits 8k+7 down to 8k.
- R2: When several active flags are high, the active device with the lowest port index is selected.
- R3: The selected device sees the host read enable. Every other device sees its read enable low.
- R4: The selected device sees the host write enable. Every other device sees its write enable low.
- R5: The host read word equals the read word of the selected device. The read words of unselected devices have no effect on it.
- R6: The host ready equals the ready flag of the selected device. The ready flags of unselected devices have no effect on it.
- R7: With no active flag high, the host read word is zero, the host ready is low, and every device read and write enable is low, whatever the host enables are.
- R8: Outputs follow inputs within the same cycle. No register lies on any path through the hub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_addr | input | ADDR_W | Address of the host access |
| host_wdata | input | DATA_W | Host write word |
| host_wmask | input | DATA_W/8 | Host byte-lane write mask |
| host_ren | input | 1 | Host read enable |
| host_wen | input | 1 | Host write enable |
| host_rdata | output | DATA_W | Read word returned to the host |
| host_ready | output | 1 | Completion flag returned to the host |
| dev_addr | output | NUM_DEV*ADDR_W | Address copies, device d in slice d |
| dev_wdata | output | NUM_DEV*DATA_W | Write word copies, device d in slice d |
| dev_wmask | output | NUM_DEV*DATA_W/8 | Mask copies, device d in slice d |
| dev_ren | output | NUM_DEV | Gated read enable, bit d for device d |
| dev_wen | output | NUM_DEV | Gated write enable, bit d for device d |
| dev_ready | input | NUM_DEV | Completion flag from device d |
| dev_rdata | input | NUM_DEV*DATA_W | Read word from device d in slice d |
| dev_active | input | NUM_DEV | Self-select flag from device d |

## Verification
Priority selection and enable gating can fall in the same cycle. This happens when the set of active flags changes in the same cycle as the host raises read and write together. The bench provokes this with several flags high at once. It also gives unselected devices distinct read words and ready values, so a wrong pick shows up in the returned data. Each cycle the bench compares every device enable, the host read word and the host ready against a behavioural model that scans for the lowest active index. A separate run of cycles with no active device and the host enables high checks that the enables are suppressed and that the host sees zero.

// File: rtl/bus_hub_pkg.sv
package bus_hub_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic {
      ENC_ISOLATE = 1'b0,
      ENC_CHAIN   = 1'b1
   } enc_style_e;

   function automatic int unsigned lane_count(int unsigned word_w);
      return word_w / BYTE_W;
   endfunction
endpackage

// File: rtl/hub_prio_pick.sv
module hub_prio_pick #(
   parameter int unsigned            N     = 4,
   parameter bus_hub_pkg::enc_style_e STYLE = bus_hub_pkg::ENC_ISOLATE
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   generate
      if (N < 1) begin : g_bad_n
         $error("hub_prio_pick: N must be at least 1");
      end
      if (STYLE == bus_hub_pkg::ENC_ISOLATE) begin : g_isolate
         logic [N-1:0] neg_req;
         assign neg_req = ~req + {{(N-1){1'b0}}, 1'b1};
         assign grant   = req & neg_req;
      end else begin : g_chain
         always_comb begin
            logic blocked;
            blocked = 1'b0;
            for (int i = 0; i < int'(N); i++) begin
               grant[i] = req[i] & ~blocked;
               blocked  = blocked | req[i];
            end
         end
      end
   endgenerate

   assign any = |req;
endmodule

// File: rtl/hub_fanout.sv
module hub_fanout #(
   parameter int unsigned N      = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MASK_W = DATA_W / 8
) (
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic [DATA_W-1:0]   host_wdata,
   input  logic [MASK_W-1:0]   host_wmask,
   input  logic                host_ren,
   input  logic                host_wen,
   input  logic [N-1:0]        grant,
   output logic [N*ADDR_W-1:0] dev_addr,
   output logic [N*DATA_W-1:0] dev_wdata,
   output logic [N*MASK_W-1:0] dev_wmask,
   output logic [N-1:0]        dev_ren,
   output logic [N-1:0]        dev_wen
);
   for (genvar d = 0; d < int'(N); d++) begin : g_port
      assign dev_addr [d*ADDR_W +: ADDR_W] = host_addr;
      assign dev_wdata[d*DATA_W +: DATA_W] = host_wdata;
      assign dev_wmask[d*MASK_W +: MASK_W] = host_wmask;
      assign dev_ren[d] = grant[d] & host_ren;
      assign dev_wen[d] = grant[d] & host_wen;
   end
endmodule

// File: rtl/hub_return.sv
module hub_return #(
   parameter int unsigned N      = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic [N-1:0]        grant,
   input  logic [N-1:0]        dev_ready,
   input  logic [N*DATA_W-1:0] dev_rdata,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                host_ready
);
   logic [DATA_W-1:0] term [N];
   logic [N-1:0]      rdy_term;

   for (genvar d = 0; d < int'(N); d++) begin : g_term
      assign term[d]     = dev_rdata[d*DATA_W +: DATA_W] & {DATA_W{grant[d]}};
      assign rdy_term[d] = dev_ready[d] & grant[d];
   end

   always_comb begin
      host_rdata = '0;
      for (int d = 0; d < int'(N); d++) host_rdata = host_rdata | term[d];
   end

   assign host_ready = |rdy_term;
endmodule

// File: rtl/bus_hub_selfsel.sv
module bus_hub_selfsel #(
   parameter int unsigned             NUM_DEV   = 4,
   parameter int unsigned             ADDR_W    = 32,
   parameter int unsigned             DATA_W    = 32,
   parameter bus_hub_pkg::enc_style_e ENC_STYLE = bus_hub_pkg::ENC_ISOLATE,
   localparam int unsigned            MASK_W    = bus_hub_pkg::lane_count(DATA_W)
) (
   input  logic [ADDR_W-1:0]          host_addr,
   input  logic [DATA_W-1:0]          host_wdata,
   input  logic [MASK_W-1:0]          host_wmask,
   input  logic                       host_ren,
   input  logic                       host_wen,
   output logic [DATA_W-1:0]          host_rdata,
   output logic                       host_ready,
   output logic [NUM_DEV*ADDR_W-1:0]  dev_addr,
   output logic [NUM_DEV*DATA_W-1:0]  dev_wdata,
   output logic [NUM_DEV*MASK_W-1:0]  dev_wmask,
   output logic [NUM_DEV-1:0]         dev_ren,
   output logic [NUM_DEV-1:0]         dev_wen,
   input  logic [NUM_DEV-1:0]         dev_ready,
   input  logic [NUM_DEV*DATA_W-1:0]  dev_rdata,
   input  logic [NUM_DEV-1:0]         dev_active
);
   generate
      if (NUM_DEV < 1) begin : g_bad_count
         $error("bus_hub_selfsel: NUM_DEV must be at least 1");
      end
      if (DATA_W % bus_hub_pkg::BYTE_W != 0 || DATA_W == 0) begin : g_bad_width
         $error("bus_hub_selfsel: DATA_W must be a nonzero multiple of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("bus_hub_selfsel: ADDR_W must be at least 1");
      end
   endgenerate

   logic [NUM_DEV-1:0] grant;
   logic               any_active;

   hub_prio_pick #(.N(NUM_DEV), .STYLE(ENC_STYLE)) u_pick (
      .req   (dev_active),
      .grant (grant),
      .any   (any_active)
   );

   hub_fanout #(.N(NUM_DEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_fan (
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_wmask (host_wmask),
      .host_ren   (host_ren),
      .host_wen   (host_wen),
      .grant      (grant),
      .dev_addr   (dev_addr),
      .dev_wdata  (dev_wdata),
      .dev_wmask  (dev_wmask),
      .dev_ren    (dev_ren),
      .dev_wen    (dev_wen)
   );

   logic [DATA_W-1:0] ret_rdata;
   logic              ret_ready;

   hub_return #(.N(NUM_DEV), .DATA_W(DATA_W)) u_ret (
      .grant      (grant),
      .dev_ready  (dev_ready),
      .dev_rdata  (dev_rdata),
      .host_rdata (ret_rdata),
      .host_ready (ret_ready)
   );

   assign host_rdata = any_active ? ret_rdata : '0;
   assign host_ready = any_active & ret_ready;
endmodule

// File: rtl/bus_hub_selfsel_chk.sv
module bus_hub_selfsel_chk #(
   parameter int unsigned NUM_DEV = 4,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned MASK_W  = DATA_W / 8
) (
   input logic [ADDR_W-1:0]         host_addr,
   input logic [DATA_W-1:0]         host_wdata,
   input logic [MASK_W-1:0]         host_wmask,
   input logic                      host_ren,
   input logic                      host_wen,
   input logic [DATA_W-1:0]         host_rdata,
   input logic                      host_ready,
   input logic [NUM_DEV*ADDR_W-1:0] dev_addr,
   input logic [NUM_DEV*DATA_W-1:0] dev_wdata,
   input logic [NUM_DEV*MASK_W-1:0] dev_wmask,
   input logic [NUM_DEV-1:0]        dev_ren,
   input logic [NUM_DEV-1:0]        dev_wen,
   input logic [NUM_DEV-1:0]        dev_ready,
   input logic [NUM_DEV*DATA_W-1:0] dev_rdata,
   input logic [NUM_DEV-1:0]        dev_active
);
   always_comb begin
      for (int d = 0; d < int'(NUM_DEV); d++) begin
         // R1
         bcast_copy_chk: assert (dev_addr[d*ADDR_W +: ADDR_W] == host_addr
                                 && dev_wdata[d*DATA_W +: DATA_W] == host_wdata
                                 && dev_wmask[d*MASK_W +: MASK_W] == host_wmask)
            else $error("broadcast mismatch on port %0d", d);
         // R2
         enable_needs_active_chk: assert (!(dev_ren[d] || dev_wen[d]) || dev_active[d])
            else $error("enable on inactive port %0d", d);
         for (int j = 0; j < d; j++) begin
            // R2
            lower_wins_chk: assert (!((dev_ren[d] || dev_wen[d]) && dev_active[j]))
               else $error("port %0d enabled while port %0d active", d, j);
         end
         // R3
         ren_follows_host_chk: assert (!dev_ren[d] || host_ren)
            else $error("read enable without host read");
         // R4
         wen_follows_host_chk: assert (!dev_wen[d] || host_wen)
            else $error("write enable without host write");
         // R5
         rdata_from_reader_chk: assert (!dev_ren[d] || host_rdata == dev_rdata[d*DATA_W +: DATA_W])
            else $error("read word not from enabled port %0d", d);
         // R6
         ready_from_target_chk: assert (!(dev_ren[d] || dev_wen[d]) || host_ready == dev_ready[d])
            else $error("ready not from enabled port %0d", d);
      end
      // R3
      single_reader_chk: assert ($onehot0(dev_ren)) else $error("several read enables");
      // R4
      single_writer_chk: assert ($onehot0(dev_wen)) else $error("several write enables");
      // R7
      idle_quiet_chk: assert (dev_active != '0
                              || (host_rdata == '0 && !host_ready && dev_ren == '0 && dev_wen == '0))
         else $error("activity with no active device");
   end
endmodule

bind bus_hub_selfsel bus_hub_selfsel_chk #(
   .NUM_DEV (NUM_DEV),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .MASK_W  (MASK_W)
) u_chk (.*);

// File: tb/bus_hub_selfsel_test.sv
module bus_hub_selfsel_test;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int MW = DW / 8;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [AW-1:0]   host_addr  = '0;
   logic [DW-1:0]   host_wdata = '0;
   logic [MW-1:0]   host_wmask = '0;
   logic            host_ren   = 1'b0;
   logic            host_wen   = 1'b0;
   logic [DW-1:0]   host_rdata;
   logic            host_ready;
   logic [N*AW-1:0] dev_addr;
   logic [N*DW-1:0] dev_wdata;
   logic [N*MW-1:0] dev_wmask;
   logic [N-1:0]    dev_ren;
   logic [N-1:0]    dev_wen;
   logic [N-1:0]    dev_ready  = '0;
   logic [N*DW-1:0] dev_rdata  = '0;
   logic [N-1:0]    dev_active = '0;

   bus_hub_selfsel #(.NUM_DEV(N), .ADDR_W(AW), .DATA_W(DW),
                     .ENC_STYLE(bus_hub_pkg::ENC_ISOLATE)) uut (.*);

   int checks = 0;
   int failures = 0;
   bit compare_on = 1'b0;
   bit finished = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int winner(logic [N-1:0] a);
      for (int i = 0; i < N; i++) if (a[i]) return i;
      return -1;
   endfunction

   // per-cycle reference comparison
   always @(negedge clk) begin
      if (compare_on) begin
         int w;
         logic [N-1:0] er, ew;
         logic [DW-1:0] ed;
         logic erdy;
         w = winner(dev_active);
         er = '0; ew = '0; ed = '0; erdy = 1'b0;
         if (w >= 0) begin
            er[w] = host_ren;
            ew[w] = host_wen;
            ed    = dev_rdata[w*DW +: DW];
            erdy  = dev_ready[w];
         end
         for (int d = 0; d < N; d++) begin
            chk("R1 addr",  64'(dev_addr[d*AW +: AW]),  64'(host_addr));
            chk("R1 wdata", 64'(dev_wdata[d*DW +: DW]), 64'(host_wdata));
            chk("R1 mask",  64'(dev_wmask[d*MW +: MW]), 64'(host_wmask));
         end
         if (w < 0) begin
            chk("R7 idle rdata", 64'(host_rdata), 64'd0);
            chk("R7 idle ready", 64'(host_ready), 64'd0);
            chk("R7 idle enables", 64'({dev_ren, dev_wen}), 64'd0);
         end else begin
            chk("R2 R3 read enables", 64'(dev_ren), 64'(er));
            chk("R2 R4 write enables", 64'(dev_wen), 64'(ew));
            chk("R5 R8 host rdata", 64'(host_rdata), 64'(ed));
            chk("R6 R8 host ready", 64'(host_ready), 64'(erdy));
         end
      end
   end

   task automatic step();
      @(posedge clk);
   endtask

   task automatic load_devs();
      for (int d = 0; d < N; d++) dev_rdata[d*DW +: DW] = 32'hA0B0_0000 + 32'(d * 32'h1111);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      step();
      @(negedge clk);
      // reset state, all inputs zero: R7
      chk("R7 reset rdata", 64'(host_rdata), 64'd0);
      chk("R7 reset ready", 64'(host_ready), 64'd0);
      chk("R7 reset enables", 64'({dev_ren, dev_wen}), 64'd0);
      compare_on = 1'b1;
      load_devs();
      dev_ready = 4'b1010;

      // R7: host enables with nobody active
      step(); host_ren = 1'b1; host_wen = 1'b1; host_addr = 32'h1000_0040;
      step(); host_wmask = 4'b0101; host_wdata = 32'hDEAD_BEEF;

      // R2..R6: every single device in turn
      for (int d = 0; d < N; d++) begin
         step(); dev_active = 4'(1 << d); host_ren = 1'b1; host_wen = 1'b0;
         step(); host_ren = 1'b0; host_wen = 1'b1;
      end

      // R2: contention, read and write together, selection changing each cycle
      step(); dev_active = 4'b1111; host_ren = 1'b1; host_wen = 1'b1;
      step(); dev_active = 4'b1110;
      step(); dev_active = 4'b1100;
      step(); dev_active = 4'b1010;
      step(); dev_active = 4'b0110; dev_ready = 4'b0100;
      @(negedge clk);
      chk("R2 pick port1 over port2", 64'(dev_ren), 64'b0010);
      chk("R6 ready of port1 not port2", 64'(host_ready), 64'd0);

      // R5/R6: unselected device changes have no effect
      step(); dev_active = 4'b0011; dev_ready = 4'b0001;
      dev_rdata[1*DW +: DW] = 32'h5555_5555;
      @(negedge clk);
      chk("R5 ignore unselected rdata", 64'(host_rdata), 64'hA0B0_0000);
      chk("R6 ready port0", 64'(host_ready), 64'd1);

      // R8: selection follows active in the same cycle
      step(); dev_active = 4'b1000;
      @(negedge clk);
      chk("R8 same-cycle switch", 64'(host_rdata), 64'hA0B0_3333);

      // random traffic
      for (int k = 0; k < 400; k++) begin
         step();
         dev_active = 4'($urandom);
         dev_ready  = 4'($urandom);
         host_ren   = 1'($urandom);
         host_wen   = 1'($urandom);
         host_addr  = $urandom;
         host_wdata = $urandom;
         host_wmask = 4'($urandom);
         for (int d = 0; d < N; d++) dev_rdata[d*DW +: DW] = $urandom;
      end
      step();
      compare_on = 1'b0;
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule